// File: doc/BRIEF.md
# Byte Mailbox Bridge Between Two Processors

This block lets a host processor and a coprocessor trade single bytes without sharing memory. There are two one-byte latches, one for each direction. When one side stores a byte, that byte is held for the other side. At the same time an active-low interrupt line toward the receiver goes low. The line stays low until the receiver reads the byte back.

Each side also owns a busy flag, and software on the other side can see it in its status byte. Reset sets both busy flags. Each side's software clears its own flag once it is ready to exchange traffic. The coprocessor side also holds a small memory bank selector, which it writes together with its busy flag.

Both bus ports are synchronous to one clock. Each port has a chip select, read and write strobes, a 2-bit offset and a byte of write data. Read data comes back registered, one cycle after the strobe.

Top module: `mailbox_bridge`

## Requirements
- R1: After reset, both busy flags are 1, both interrupt outputs are high, `bank_sel` is 0 and both read-data outputs are 0.
- R2: A host write to offset 1 stores the byte for the coprocessor. `cop_irq_n` is low from the cycle after the write. A coprocessor read of offset 2 returns that byte.
- R3: A coprocessor read of offset 2 sets `cop_irq_n` high on the cycle after the read. With no such read, `cop_irq_n` stays low for any number of cycles.
- R4: A coprocessor write to offset 1 stores a byte for the host and drives `host_irq_n` low. A host read of offset 2 returns that byte and sets `host_irq_n` high on the following cycle.
- R5: A second write to a direction whose byte is still unread replaces the stored byte, and that direction's interrupt stays low.
- R6: A read of offset 0 on either side returns a status byte and changes nothing. Bit 6 is 1 while a byte for the reader is unread. Bit 7 is the other side's busy flag. All other bits are 0.
- R7: A host write to offset 2 sets the host busy flag to data bit 7 (1 = busy).
- R8: A coprocessor write to offset 3 sets the coprocessor busy flag to data bit 6 (1 = busy) and loads `bank_sel` from data bits 3..0.
- R9: If the sender writes and the receiver reads the same direction in the same cycle, the read returns the old byte. The new byte then stays pending, with the interrupt still low.
- R10: Strobes with chip select low do nothing: no byte is stored, no interrupt changes, and read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| host_irq_n | output | 1 | Active-low interrupt to the host |
| cop_cs | input | 1 | Coprocessor chip select |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_addr | input | 2 | Coprocessor register offset |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data, registered |
| cop_irq_n | output | 1 | Active-low interrupt to the coprocessor |
| bank_sel | output | 4 | Memory bank selector written by the coprocessor |

## Verification
The assertions check the following on every cycle:
- a pending flag rises after every write and stays up until a read;
- a read with no write in the same cycle drops the pending flag;
- the stored byte changes only on a write;
- each busy flag follows its own control bit;
- read data holds still when no selected read occurs.

Some behaviour only the bench scenarios can show:
- the exact layout of the status byte;
- the byte returned across the two directions;
- the overwrite order;
- the same-cycle write-and-read collision;
- the effect of the coprocessor's bank write as seen at the port.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int BYTE_W = 8;
    localparam int OFFS_W = 2;

    typedef logic [OFFS_W-1:0] offs_t;

    localparam offs_t OFS_STATUS = 2'd0;
    localparam offs_t OFS_PUT    = 2'd1;
    localparam offs_t OFS_GET    = 2'd2;
    localparam offs_t OFS_HCTL   = 2'd2;
    localparam offs_t OFS_CCTL   = 2'd3;

    localparam int ST_PEND_BIT = 6;
    localparam int ST_BUSY_BIT = 7;
    localparam int HOST_BUSY_DBIT = 7;
    localparam int COP_BUSY_DBIT  = 6;

    typedef struct packed {
        logic stat_rd;
        logic get_rd;
        logic put_wr;
        logic ctl_wr;
    } strobe_t;

    function automatic strobe_t decode_access(logic cs, logic rd, logic wr,
                                              offs_t a, offs_t ctl_ofs);
        strobe_t s;
        s.stat_rd = cs && rd && (a == OFS_STATUS);
        s.get_rd  = cs && rd && (a == OFS_GET);
        s.put_wr  = cs && wr && (a == OFS_PUT);
        s.ctl_wr  = cs && wr && (a == ctl_ofs);
        return s;
    endfunction
endpackage

// File: rtl/mbx_lane.sv
module mbx_lane #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              get,
    output logic [DATA_W-1:0] held,
    output logic              pend
);
    logic [DATA_W-1:0] held_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (put)
                held_q <= put_data;
            if (put)
                pend_q <= 1'b1;
            else if (get)
                pend_q <= 1'b0;
        end
    end

    assign held = held_q;
    assign pend = pend_q;

    // R2
    put_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        put |=> pend_q);
    // R2
    put_stores_chk: assert property (@(posedge clk) disable iff (rst)
        put |=> held_q == $past(put_data));
    // R3
    get_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (get && !put) |=> !pend_q);
    // R3
    pend_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !get) |=> pend_q);
    // R10
    byte_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !put |=> $stable(held_q));
endmodule

// File: rtl/side_port.sv
module side_port
    import bridge_pkg::*;
#(
    parameter int    DATA_W    = 8,
    parameter int    BANK_W    = 4,
    parameter int    BUSY_DBIT = 7,
    parameter offs_t CTL_OFS   = 2'd2,
    parameter bit    HAS_BANK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  offs_t             addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              in_pend,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              peer_busy,
    output logic              put,
    output logic              get,
    output logic              busy,
    output logic [BANK_W-1:0] bank,
    output logic [DATA_W-1:0] rdata
);
    strobe_t           stb;
    logic [DATA_W-1:0] stat_byte;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic              busy_q;

    assign stb = decode_access(cs, rd, wr, addr, CTL_OFS);
    assign put = stb.put_wr;
    assign get = stb.get_rd;

    always_comb begin
        stat_byte = '0;
        stat_byte[ST_PEND_BIT] = in_pend;
        stat_byte[ST_BUSY_BIT] = peer_busy;
    end

    always_comb begin
        if (stb.stat_rd)
            rd_next = stat_byte;
        else if (stb.get_rd)
            rd_next = in_byte;
        else
            rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            busy_q  <= 1'b1;
        end else begin
            if (cs && rd)
                rdata_q <= rd_next;
            if (stb.ctl_wr)
                busy_q <= wdata[BUSY_DBIT];
        end
    end

    generate
        if (HAS_BANK) begin : g_bank
            logic [BANK_W-1:0] bank_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bank_q <= '0;
                else if (stb.ctl_wr)
                    bank_q <= wdata[BANK_W-1:0];
            end
            assign bank = bank_q;
        end else begin : g_nobank
            assign bank = '0;
        end
    endgenerate

    assign busy  = busy_q;
    assign rdata = rdata_q;

    // R7 R8
    busy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        stb.ctl_wr |=> busy_q == $past(wdata[BUSY_DBIT]));
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |=> $stable(rdata_q));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(busy_q));
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge
    import bridge_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq_n,
    input  logic              cop_cs,
    input  logic              cop_rd,
    input  logic              cop_wr,
    input  logic [1:0]        cop_addr,
    input  logic [DATA_W-1:0] cop_wdata,
    output logic [DATA_W-1:0] cop_rdata,
    output logic              cop_irq_n,
    output logic [BANK_W-1:0] bank_sel
);
    logic              h_put, h_get, c_put, c_get;
    logic              h_busy, c_busy;
    logic [DATA_W-1:0] to_cop_byte, to_host_byte;
    logic              to_cop_pend, to_host_pend;
    logic [BANK_W-1:0] h_bank_unused;

    mbx_lane #(.DATA_W(DATA_W)) u_to_cop (
        .clk(clk), .rst(rst),
        .put(h_put), .put_data(host_wdata), .get(c_get),
        .held(to_cop_byte), .pend(to_cop_pend)
    );

    mbx_lane #(.DATA_W(DATA_W)) u_to_host (
        .clk(clk), .rst(rst),
        .put(c_put), .put_data(cop_wdata), .get(h_get),
        .held(to_host_byte), .pend(to_host_pend)
    );

    side_port #(
        .DATA_W(DATA_W), .BANK_W(BANK_W), .BUSY_DBIT(HOST_BUSY_DBIT),
        .CTL_OFS(OFS_HCTL), .HAS_BANK(1'b0)
    ) u_host_port (
        .clk(clk), .rst(rst),
        .cs(host_cs), .rd(host_rd), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .in_pend(to_host_pend), .in_byte(to_host_byte),
        .peer_busy(c_busy), .put(h_put), .get(h_get), .busy(h_busy),
        .bank(h_bank_unused), .rdata(host_rdata)
    );

    side_port #(
        .DATA_W(DATA_W), .BANK_W(BANK_W), .BUSY_DBIT(COP_BUSY_DBIT),
        .CTL_OFS(OFS_CCTL), .HAS_BANK(1'b1)
    ) u_cop_port (
        .clk(clk), .rst(rst),
        .cs(cop_cs), .rd(cop_rd), .wr(cop_wr), .addr(cop_addr),
        .wdata(cop_wdata), .in_pend(to_cop_pend), .in_byte(to_cop_byte),
        .peer_busy(h_busy), .put(c_put), .get(c_get), .busy(c_busy),
        .bank(bank_sel), .rdata(cop_rdata)
    );

    assign host_irq_n = ~to_host_pend;
    assign cop_irq_n  = ~to_cop_pend;

    // R1
    bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
        h_bank_unused == '0);
    // R9
    collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (h_put && c_get) |=> !cop_irq_n);
endmodule

// File: tb/tb_mailbox_bridge.sv
module tb_mailbox_bridge;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs = 0, host_rd = 0, host_wr = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_irq_n;
    logic       cop_cs = 0, cop_rd = 0, cop_wr = 0;
    logic [1:0] cop_addr = 0;
    logic [7:0] cop_wdata = 0;
    logic [7:0] cop_rdata;
    logic       cop_irq_n;
    logic [3:0] bank_sel;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    mailbox_bridge dut (
        .clk(clk), .rst(rst),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_irq_n(host_irq_n),
        .cop_cs(cop_cs), .cop_rd(cop_rd), .cop_wr(cop_wr),
        .cop_addr(cop_addr), .cop_wdata(cop_wdata),
        .cop_rdata(cop_rdata), .cop_irq_n(cop_irq_n),
        .bank_sel(bank_sel)
    );

    typedef struct packed {
        logic       cop;
        logic       wr;
        logic [1:0] ofs;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h80, 8'd6},  // R6 cop busy after reset
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h80, 8'd1},  // R1 host busy after reset
        '{1'b1, 1'b1, 2'd3, 8'h05, 8'h00, 8'd8},  // R8 cop ready, bank 5
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 8'd8},  // R8 status shows cop idle
        '{1'b0, 1'b1, 2'd1, 8'hA5, 8'h00, 8'd2},  // R2 host sends
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'hC0, 8'd6},  // R6 pending + host busy
        '{1'b1, 1'b0, 2'd2, 8'h00, 8'hA5, 8'd2},  // R2 cop receives
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h80, 8'd3},  // R3 pending cleared
        '{1'b0, 1'b1, 2'd2, 8'h7F, 8'h00, 8'd7},  // R7 host busy cleared
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'd7},  // R7
        '{1'b1, 1'b1, 2'd1, 8'h3C, 8'h00, 8'd4},  // R4 cop sends
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h40, 8'd4},  // R4
        '{1'b0, 1'b0, 2'd2, 8'h00, 8'h3C, 8'd4},  // R4 host receives
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 8'd4},  // R4 cleared
        '{1'b0, 1'b1, 2'd1, 8'h11, 8'h00, 8'd5},  // R5 first byte
        '{1'b0, 1'b1, 2'd1, 8'h22, 8'h00, 8'd5},  // R5 overwrite
        '{1'b1, 1'b0, 2'd2, 8'h00, 8'h22, 8'd5},  // R5 newest wins
        '{1'b1, 1'b1, 2'd3, 8'h4A, 8'h00, 8'd8},  // R8 cop busy again
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h80, 8'd8}   // R8
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic side, input logic w, input logic [1:0] a,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        if (side) begin
            cop_cs = 1; cop_rd = !w; cop_wr = w; cop_addr = a; cop_wdata = d;
        end else begin
            host_cs = 1; host_rd = !w; host_wr = w; host_addr = a; host_wdata = d;
        end
        @(negedge clk);
        cop_cs = 0; cop_rd = 0; cop_wr = 0;
        host_cs = 0; host_rd = 0; host_wr = 0;
        q = side ? cop_rdata : host_rdata;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset values
        check("R1", {7'd0, host_irq_n}, 8'h01);
        check("R1", {7'd0, cop_irq_n}, 8'h01);
        check("R1", {4'd0, bank_sel}, 8'h00);
        check("R1", host_rdata, 8'h00);
        check("R1", cop_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].cop, VECS[i].wr, VECS[i].ofs, VECS[i].dat, q);
            if (!VECS[i].wr)
                check($sformatf("R%0d", VECS[i].req), q, VECS[i].exp);
        end
        // R8 bank from last control write (4A -> A)
        check("R8", {4'd0, bank_sel}, 8'h0A);

        // R3 interrupt holds until read
        access(1'b0, 1'b1, 2'd1, 8'h99, q);
        check("R2", {7'd0, cop_irq_n}, 8'h00);
        repeat (5) @(negedge clk);
        check("R3", {7'd0, cop_irq_n}, 8'h00);

        // R10 strobes without chip select
        q = cop_rdata;
        @(negedge clk);
        cop_rd = 1; cop_addr = 2'd2;
        host_wr = 1; host_addr = 2'd1; host_wdata = 8'hEE;
        @(negedge clk);
        cop_rd = 0; host_wr = 0;
        check("R10", cop_rdata, q);
        check("R10", {7'd0, cop_irq_n}, 8'h00);
        access(1'b1, 1'b0, 2'd2, 8'h00, q);
        check("R10", q, 8'h99);
        check("R3", {7'd0, cop_irq_n}, 8'h01);

        // R9 same-cycle write and read
        access(1'b0, 1'b1, 2'd1, 8'h55, q);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = 2'd1; host_wdata = 8'h66;
        cop_cs = 1; cop_rd = 1; cop_addr = 2'd2;
        @(negedge clk);
        host_cs = 0; host_wr = 0; cop_cs = 0; cop_rd = 0;
        check("R9", cop_rdata, 8'h55);
        check("R9", {7'd0, cop_irq_n}, 8'h00);
        access(1'b1, 1'b0, 2'd2, 8'h00, q);
        check("R9", q, 8'h66);
        check("R9", {7'd0, cop_irq_n}, 8'h01);

        // R6 status read has no side effect on pending byte
        access(1'b1, 1'b1, 2'd1, 8'h5A, q);
        access(1'b0, 1'b0, 2'd0, 8'h00, q);
        check("R6", q, 8'hC0);
        check("R6", {7'd0, host_irq_n}, 8'h00);
        access(1'b0, 1'b0, 2'd2, 8'h00, q);
        check("R4", q, 8'h5A);
        check("R4", {7'd0, host_irq_n}, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule